// File: doc/BRIEF.md
# Register Rename Map with Free List

This block renames one instruction per clock. It turns the architectural source and destination register numbers into physical register tags through a speculative mapping table. Each destination receives a fresh physical register taken from a free list. The physical register space is twice the size of the architectural register space. Because every write gets a new physical register, write-after-write and write-after-read conflicts between in-flight instructions disappear.

For every instruction the block reports two source tags, the new destination tag and the tag the destination held before. The old tag travels with the instruction down the pipeline. When the commit stage retires that instruction, it hands the old tag back, and only then does the old tag return to the free list. The commit stage also updates a second, committed mapping table. A flush copies the committed table over the speculative one and rebuilds the free list from every physical register that the committed table does not hold. This restores precise state after a misprediction or an exception.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. Physical tags NARCH to NPHYS-1 are free, so the first destination allocated after reset receives tag NARCH (32 by default).
- R2: Source tags come from the speculative map as it stood before the current cycle's destination update. An instruction whose source equals its destination therefore sees the older tag.
- R3: A renamed destination receives the lowest-numbered free physical tag. `old_tag` equals the tag the destination mapped to before this rename.
- R4: From the cycle after a rename, reads of that architectural register return the newly allocated tag.
- R5: An accepted instruction with `ren_has_dst`=0 takes no tag from the free list. The next destination rename receives the same tag it would have received without that instruction.
- R6: `ren_ready` is 0 when the free list is empty and `ren_has_dst`=1. `ren_ready` is 1 for an instruction without a destination when no flush is present.
- R7: A commit with `commit_valid`=1 returns `commit_old_tag` to the free list. From the next cycle that tag can be allocated again. The commit also records `commit_new_tag` as the committed mapping of `commit_arch`.
- R8: On `flush`, the speculative map becomes the committed map, including any commit presented in the same cycle. The free list becomes exactly the set of tags that the committed map does not hold.
- R9: While `flush` is 1, `ren_ready` is 0 and no rename takes effect.
- R10: A cycle with `ren_valid`=0 changes neither the map nor the free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| ren_valid | input | 1 | An instruction is offered for renaming |
| ren_has_dst | input | 1 | The offered instruction writes a register |
| ren_src1 | input | AW | First architectural source register |
| ren_src2 | input | AW | Second architectural source register |
| ren_dst | input | AW | Architectural destination register |
| ren_ready | output | 1 | The offered instruction is accepted this cycle |
| src1_tag | output | PW | Physical tag of the first source |
| src2_tag | output | PW | Physical tag of the second source |
| dst_tag | output | PW | Newly allocated physical tag for the destination |
| old_tag | output | PW | Previous physical tag of the destination |
| commit_valid | input | 1 | A destination-writing instruction retires |
| commit_arch | input | AW | Architectural register of the retiring instruction |
| commit_new_tag | input | PW | Tag the retiring instruction was given |
| commit_old_tag | input | PW | Tag to release to the free list |
| flush | input | 1 | Restore the speculative state to the committed state |

## Verification
The main function is driven in several ways: a single rename right after reset, an instruction that reads and writes the same register, instructions without a destination, and offers with `ren_valid` low. The reset case fixes the identity mapping and the first allocated tag. The same-register case shows whether sources are read before or after the table update. The last two cases show whether a free-list entry leaks. Renames that run until the free list is empty show the stall, and also show that instructions without a destination still pass. Commits that release low-numbered tags show the lowest-free allocation order and recycling. A flush presented in the same cycle as a commit checks that the restored map and the rebuilt free list include that commit.

// File: rtl/rename_pkg.sv
// Package: shared sizing for the register rename unit.
// Assumes the architectural register count is a power of two.
package rename_pkg;
    parameter int unsigned DEF_ARCH_REGS = 32;
    localparam int unsigned DEF_PHYS_REGS = 2 * DEF_ARCH_REGS;

    // Width of an index into a table of n entries (at least 1 bit).
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rn_map_table.sv
// Module: rn_map_table
// Holds one tag per architectural register. It supports a single write port
// and a whole-table load, and it exposes the whole table so that the parent
// can read it. The whole-table load takes priority over the single write.
// Assumes NARCH <= 2**PW.
module rn_map_table #(
    parameter int unsigned NARCH = 32,
    parameter int unsigned AW    = 5,
    parameter int unsigned PW    = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_idx,
    input  logic [PW-1:0]              wr_tag,
    input  logic                       load_en,
    input  logic [NARCH-1:0][PW-1:0]   load_image,
    output logic [NARCH-1:0][PW-1:0]   image
);
    logic [NARCH-1:0][PW-1:0] img_q;

    // Table state: identity at reset, bulk load on restore, else single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NARCH; i++) begin
                img_q[i] <= PW'(i);
            end
        end else if (load_en) begin
            img_q <= load_image;
        end else if (wr_en) begin
            img_q[wr_idx] <= wr_tag;
        end
    end

    assign image = img_q;
endmodule

// File: rtl/rn_free_list.sv
// Module: rn_free_list
// Keeps one bit per physical register; a set bit means the tag is free.
// It offers the lowest-numbered free tag, clears it on allocation and sets a
// bit on release. A restore replaces the whole set and takes priority.
// Assumes the caller never allocates while the list is empty.
module rn_free_list #(
    parameter int unsigned NARCH = 32,
    parameter int unsigned NPHYS = 64,
    parameter int unsigned PW    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    output logic [PW-1:0]     alloc_tag,
    output logic              empty,
    input  logic              release_en,
    input  logic [PW-1:0]     release_tag,
    input  logic              restore_en,
    input  logic [NPHYS-1:0]  restore_mask,
    output logic [NPHYS-1:0]  bits
);
    logic [NPHYS-1:0] bits_q;
    logic [NPHYS-1:0] bits_d;
    logic [NPHYS-1:0] reset_mask;

    // Reset contents: every tag above the identity mapping is free.
    always_comb begin
        for (int i = 0; i < NPHYS; i++) begin
            reset_mask[i] = (i >= NARCH);
        end
    end

    // Priority pick: scan downward so the lowest set bit wins.
    always_comb begin
        alloc_tag = '0;
        for (int i = NPHYS - 1; i >= 0; i--) begin
            if (bits_q[i]) begin
                alloc_tag = PW'(i);
            end
        end
    end

    // Next-state set: allocation clears a bit, release sets one.
    always_comb begin
        bits_d = bits_q;
        if (alloc_en) begin
            bits_d[alloc_tag] = 1'b0;
        end
        if (release_en) begin
            bits_d[release_tag] = 1'b1;
        end
    end

    // Free-set register with reset and restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= reset_mask;
        end else if (restore_en) begin
            bits_q <= restore_mask;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign empty = ~|bits_q;
    assign bits  = bits_q;
endmodule

// File: rtl/rn_commit_view.sv
// Module: rn_commit_view
// Forms the committed table as it will be after this cycle's commit write,
// and the set of physical tags that this table does not hold. A flush uses
// both to rebuild the speculative state.
// Assumes the committed table never maps two registers to one tag.
module rn_commit_view #(
    parameter int unsigned NARCH = 32,
    parameter int unsigned NPHYS = 64,
    parameter int unsigned AW    = 5,
    parameter int unsigned PW    = 6
) (
    input  logic [NARCH-1:0][PW-1:0] image,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_idx,
    input  logic [PW-1:0]            wr_tag,
    output logic [NARCH-1:0][PW-1:0] next_image,
    output logic [NPHYS-1:0]         unheld_mask
);
    logic [NPHYS-1:0] held;

    // Committed table including the write that commits this cycle.
    always_comb begin
        next_image = image;
        if (wr_en) begin
            next_image[wr_idx] = wr_tag;
        end
    end

    // Mark every tag referenced by the post-commit table as held.
    always_comb begin
        held = '0;
        for (int i = 0; i < NARCH; i++) begin
            held[next_image[i]] = 1'b1;
        end
        unheld_mask = ~held;
    end
endmodule

// File: rtl/reg_rename_unit.sv
// Module: reg_rename_unit (top)
// Renames one instruction per cycle through a speculative map and a free
// list. It returns the superseded tag so that it can be released at commit.
// It keeps a committed map for precise restore on flush.
// Assumes the commit port carries only destination-writing instructions,
// in program order, and that NARCH is a power of two.
module reg_rename_unit #(
    parameter int unsigned NARCH = rename_pkg::DEF_ARCH_REGS
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    ren_valid,
    input  logic                                    ren_has_dst,
    input  logic [rename_pkg::idx_bits(NARCH)-1:0]  ren_src1,
    input  logic [rename_pkg::idx_bits(NARCH)-1:0]  ren_src2,
    input  logic [rename_pkg::idx_bits(NARCH)-1:0]  ren_dst,
    output logic                                    ren_ready,
    output logic [rename_pkg::idx_bits(2*NARCH)-1:0] src1_tag,
    output logic [rename_pkg::idx_bits(2*NARCH)-1:0] src2_tag,
    output logic [rename_pkg::idx_bits(2*NARCH)-1:0] dst_tag,
    output logic [rename_pkg::idx_bits(2*NARCH)-1:0] old_tag,
    input  logic                                    commit_valid,
    input  logic [rename_pkg::idx_bits(NARCH)-1:0]  commit_arch,
    input  logic [rename_pkg::idx_bits(2*NARCH)-1:0] commit_new_tag,
    input  logic [rename_pkg::idx_bits(2*NARCH)-1:0] commit_old_tag,
    input  logic                                    flush
);
    localparam int unsigned NPHYS = 2 * NARCH;
    localparam int unsigned AW    = rename_pkg::idx_bits(NARCH);
    localparam int unsigned PW    = rename_pkg::idx_bits(NPHYS);

    logic [NARCH-1:0][PW-1:0] spec_image;
    logic [NARCH-1:0][PW-1:0] commit_image;
    logic [NARCH-1:0][PW-1:0] commit_next;
    logic [NPHYS-1:0]         restore_mask;
    logic [NPHYS-1:0]         free_bits;
    logic [PW-1:0]            free_pick;
    logic                     free_empty;
    logic                     alloc;

    // Acceptance: blocked by flush, and by an empty list if a tag is needed.
    assign ren_ready = ~flush & (~ren_has_dst | ~free_empty);
    assign alloc     = ren_valid & ren_ready & ren_has_dst;

    // Read ports: sources and old destination from the pre-update table.
    assign src1_tag = spec_image[ren_src1];
    assign src2_tag = spec_image[ren_src2];
    assign old_tag  = spec_image[ren_dst];
    assign dst_tag  = free_pick;

    rn_map_table #(.NARCH(NARCH), .AW(AW), .PW(PW)) u_spec_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (alloc),
        .wr_idx     (ren_dst),
        .wr_tag     (free_pick),
        .load_en    (flush),
        .load_image (commit_next),
        .image      (spec_image)
    );

    rn_map_table #(.NARCH(NARCH), .AW(AW), .PW(PW)) u_commit_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (commit_valid),
        .wr_idx     (commit_arch),
        .wr_tag     (commit_new_tag),
        .load_en    (1'b0),
        .load_image (commit_image),
        .image      (commit_image)
    );

    rn_commit_view #(.NARCH(NARCH), .NPHYS(NPHYS), .AW(AW), .PW(PW)) u_view (
        .image       (commit_image),
        .wr_en       (commit_valid),
        .wr_idx      (commit_arch),
        .wr_tag      (commit_new_tag),
        .next_image  (commit_next),
        .unheld_mask (restore_mask)
    );

    rn_free_list #(.NARCH(NARCH), .NPHYS(NPHYS), .PW(PW)) u_free (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_en     (alloc),
        .alloc_tag    (free_pick),
        .empty        (free_empty),
        .release_en   (commit_valid),
        .release_tag  (commit_old_tag),
        .restore_en   (flush),
        .restore_mask (restore_mask),
        .bits         (free_bits)
    );
endmodule

// File: rtl/reg_rename_checks.sv
// Module: reg_rename_checks
// Temporal checks on the rename unit, attached through bind. It observes the
// ports together with the free set and both tables.
module reg_rename_checks #(
    parameter int unsigned NARCH = 32,
    parameter int unsigned NPHYS = 64,
    parameter int unsigned AW    = 5,
    parameter int unsigned PW    = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ren_valid,
    input logic                     ren_has_dst,
    input logic                     ren_ready,
    input logic [AW-1:0]            ren_dst,
    input logic [PW-1:0]            dst_tag,
    input logic [PW-1:0]            old_tag,
    input logic                     flush,
    input logic                     commit_valid,
    input logic [NPHYS-1:0]         free_bits,
    input logic [NARCH-1:0][PW-1:0] spec_image,
    input logic [NARCH-1:0][PW-1:0] commit_image
);
    AST_ALLOC_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && ren_has_dst) |-> free_bits[dst_tag]); // R3

    AST_OLD_NOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && ren_has_dst) |-> !free_bits[old_tag]); // R3

    AST_NEW_MAPPING_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && ren_has_dst && !flush)
        |=> spec_image[$past(ren_dst)] == $past(dst_tag)); // R4

    AST_NODST_KEEPS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && !ren_has_dst && !flush && !commit_valid)
        |=> $stable(free_bits)); // R5

    AST_STALL_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(free_bits) == 0 && ren_has_dst) |-> !ren_ready); // R6

    AST_FLUSH_RESTORES_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> spec_image == commit_image); // R8

    AST_FLUSH_BLOCKS_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !ren_ready); // R9

    AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren_valid && !flush && !commit_valid)
        |=> $stable(spec_image) && $stable(free_bits)); // R10
endmodule

bind reg_rename_unit reg_rename_checks #(
    .NARCH(NARCH), .NPHYS(NPHYS), .AW(AW), .PW(PW)
) u_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .ren_valid    (ren_valid),
    .ren_has_dst  (ren_has_dst),
    .ren_ready    (ren_ready),
    .ren_dst      (ren_dst),
    .dst_tag      (dst_tag),
    .old_tag      (old_tag),
    .flush        (flush),
    .commit_valid (commit_valid),
    .free_bits    (free_bits),
    .spec_image   (spec_image),
    .commit_image (commit_image)
);

// File: tb/tb_reg_rename_unit.sv
module tb_reg_rename_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 32;
    localparam int NP = 64;
    localparam int AW = 5;
    localparam int PW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ren_valid = 1'b0, ren_has_dst = 1'b0;
    logic [AW-1:0] ren_src1 = '0, ren_src2 = '0, ren_dst = '0;
    logic          ren_ready;
    logic [PW-1:0] src1_tag, src2_tag, dst_tag, old_tag;
    logic          commit_valid = 1'b0;
    logic [AW-1:0] commit_arch = '0;
    logic [PW-1:0] commit_new_tag = '0, commit_old_tag = '0;
    logic          flush = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    // Reference state kept by the bench from the requirements.
    logic [PW-1:0] m_spec [NA];
    logic [PW-1:0] m_comm [NA];
    logic [NP-1:0] m_free;
    logic [AW-1:0] q_arch [256];
    logic [PW-1:0] q_new  [256];
    logic [PW-1:0] q_old  [256];
    int q_head = 0;
    int q_tail = 0;
    logic          last_ready;
    logic [PW-1:0] last_dst;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_rename_unit #(.NARCH(NA)) dut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_has_dst(ren_has_dst),
        .ren_src1(ren_src1), .ren_src2(ren_src2), .ren_dst(ren_dst),
        .ren_ready(ren_ready), .src1_tag(src1_tag), .src2_tag(src2_tag),
        .dst_tag(dst_tag), .old_tag(old_tag),
        .commit_valid(commit_valid), .commit_arch(commit_arch),
        .commit_new_tag(commit_new_tag), .commit_old_tag(commit_old_tag),
        .flush(flush)
    );

    function automatic logic [PW-1:0] lowest_free();
        for (int i = 0; i < NP; i++) begin
            if (m_free[i]) return PW'(i);
        end
        return '0;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock: drive at negedge, check before the edge, update model at it.
    task automatic step(input logic rv, input logic rh, input int s1, input int s2, input int d,
                        input logic cv, input int ca, input int cn, input int co,
                        input logic fl, input string req);
        logic exp_ready;
        logic [PW-1:0] pick;
        @(negedge clk);
        ren_valid = rv; ren_has_dst = rh;
        ren_src1 = AW'(s1); ren_src2 = AW'(s2); ren_dst = AW'(d);
        commit_valid = cv; commit_arch = AW'(ca);
        commit_new_tag = PW'(cn); commit_old_tag = PW'(co);
        flush = fl;
        #1;
        exp_ready = !fl && (!rh || m_free != '0);
        pick = lowest_free();
        last_ready = ren_ready;
        last_dst = dst_tag;
        chk(req, "ready", int'(ren_ready), int'(exp_ready));
        chk(req, "src1_tag", int'(src1_tag), int'(m_spec[s1]));
        chk(req, "src2_tag", int'(src2_tag), int'(m_spec[s2]));
        if (rv && exp_ready && rh) begin
            chk(req, "dst_tag", int'(dst_tag), int'(pick));
            chk(req, "old_tag", int'(old_tag), int'(m_spec[d]));
        end
        @(posedge clk);
        if (fl) begin
            if (cv) m_comm[ca] = PW'(cn);
            m_free = '1;
            for (int i = 0; i < NA; i++) begin
                m_spec[i] = m_comm[i];
                m_free[m_comm[i]] = 1'b0;
            end
            q_head = 0; q_tail = 0;
        end else begin
            if (rv && exp_ready && rh) begin
                q_arch[q_tail] = AW'(d); q_new[q_tail] = pick; q_old[q_tail] = m_spec[d];
                q_tail++;
                m_spec[d] = pick;
                m_free[pick] = 1'b0;
            end
            if (cv) begin
                m_comm[ca] = PW'(cn);
                m_free[co] = 1'b1;
            end
        end
    endtask

    task automatic rename(input int s1, input int s2, input int d, input string req);
        step(1'b1, 1'b1, s1, s2, d, 1'b0, 0, 0, 0, 1'b0, req);
    endtask

    task automatic idle_read(input int s1, input int s2, input string req);
        step(1'b0, 1'b0, s1, s2, 0, 1'b0, 0, 0, 0, 1'b0, req);
    endtask

    // Retire the oldest in-flight destination, optionally with a flush.
    task automatic commit_oldest(input logic fl, input logic rv, input string req);
        int h;
        if (q_head == q_tail) return;
        h = q_head;
        q_head++;
        step(rv, 1'b1, 0, 1, 2, 1'b1, int'(q_arch[h]), int'(q_new[h]), int'(q_old[h]), fl, req);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NA; i++) begin
            idle_read(i, NA - 1 - i, "R1");
            chk("R1", "identity map", int'(src1_tag), i);
        end
        // Offer with valid low but a destination: must not allocate (R10).
        step(1'b0, 1'b1, 3, 3, 3, 1'b0, 0, 0, 0, 1'b0, "R10");
        rename(3, 4, 3, "R1");
        chk("R1", "first allocated tag", int'(last_dst), NA);
        idle_read(3, 4, "R4");
        chk("R4", "new mapping of r3", int'(src1_tag), NA);
    endtask

    task automatic t_self();
        rename(7, 7, 7, "R2");
        chk("R2", "src equals dst sees old tag", int'(last_dst), NA + 1);
        idle_read(7, 0, "R4");
        chk("R4", "r7 after rename", int'(src1_tag), NA + 1);
    endtask

    task automatic t_nodst();
        step(1'b1, 1'b0, 9, 10, 9, 1'b0, 0, 0, 0, 1'b0, "R5");
        chk("R5", "ready without destination", int'(last_ready), 1);
        rename(9, 10, 9, "R5");
        chk("R5", "tag not consumed", int'(last_dst), NA + 2);
    endtask

    task automatic t_invalid();
        step(1'b0, 1'b1, 11, 9, 11, 1'b0, 0, 0, 0, 1'b0, "R10");
        idle_read(11, 9, "R10");
        chk("R10", "r11 untouched", int'(src1_tag), 11);
        rename(11, 12, 11, "R10");
        chk("R10", "free list untouched", int'(last_dst), NA + 3);
    endtask

    task automatic t_commit();
        while (q_head != q_tail) commit_oldest(1'b0, 1'b0, "R7");
        rename(1, 2, 12, "R7");
        chk("R7", "released tag recycled", int'(last_dst), 3);
        rename(1, 2, 13, "R3");
        chk("R3", "lowest free next", int'(last_dst), 7);
    endtask

    task automatic t_exhaust();
        for (int k = 0; k < NP && m_free != '0; k++) begin
            rename(k % NA, (k + 1) % NA, (k + 5) % NA, "R6");
        end
        rename(0, 1, 2, "R6");
        chk("R6", "stall on empty list", int'(last_ready), 0);
        step(1'b1, 1'b0, 0, 1, 2, 1'b0, 0, 0, 0, 1'b0, "R6");
        chk("R6", "no-destination passes when empty", int'(last_ready), 1);
        commit_oldest(1'b0, 1'b1, "R6");
        chk("R6", "still empty during release", int'(last_ready), 0);
        rename(4, 5, 6, "R7");
        chk("R7", "ready after release", int'(last_ready), 1);
    endtask

    task automatic t_flush();
        commit_oldest(1'b0, 1'b0, "R7");
        commit_oldest(1'b1, 1'b1, "R9");
        chk("R9", "ready low during flush", int'(last_ready), 0);
        for (int i = 0; i < NA; i++) begin
            idle_read(i, i, "R8");
        end
        rename(20, 21, 20, "R8");
        rename(20, 21, 22, "R8");
        idle_read(20, 22, "R4");
    endtask

    initial begin
        for (int i = 0; i < NA; i++) begin
            m_spec[i] = PW'(i);
            m_comm[i] = PW'(i);
        end
        for (int i = 0; i < NP; i++) m_free[i] = (i >= NA);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_self();
        t_nodst();
        t_invalid();
        t_commit();
        t_exhaust();
        t_flush();
        @(negedge clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule